// File: doc/BRIEF.md
# Streaming Bit-Serial Multiplier

This block multiplies two unsigned operands of `W` bits (32 by default) for a single processing element, using one serial data line for both operands and one serial line for the result. First the multiplicand is shifted into a holding register, one bit per clock, under a load strobe. Then the multiplier arrives one bit per clock, least significant bit first, under a stream strobe. On each accepted multiplier bit, the stored multiplicand is either added into a shifting accumulator or skipped. The lowest sum bit leaves as a product bit, and the adder's carry-out shifts into the top of the accumulator.

After the last multiplier bit, the accumulator holds the high half of the product. It drains one bit per clock on its own. While it drains, the next multiplicand can already be shifted into the holding register, so multiplications can follow each other with no idle cycle. The full product has `2W` bits. It comes out least significant bit first, with a valid flag on every bit.

Top module: `serial_mult`

## Requirements
- R1: After a synchronous reset, `prod_vld`, `busy` and `err` are 0. They stay 0 while no strobe is raised.
- R2: A cycle with `ld_mcand` high and `mul_en` low shifts `sdin` into the holding register. Bits arrive least significant first. The multiplicand is the last `W` bits loaded, so loading more than `W` bits keeps only the most recent `W`.
- R3: Each accepted multiplier bit (`mul_en` high, least significant first) produces exactly one product bit on `prod_bit` with `prod_vld` high, in the next cycle.
- R4: The `2W` emitted bits, least significant first, equal the unsigned product of multiplicand and multiplier. The low `W` bits appear during the multiplier phase. The high `W` bits appear on the `W` consecutive cycles that follow the last multiplier bit, with no gap.
- R5: `prod_vld` is high for exactly `2W` cycles per multiplication. A cycle with `mul_en` low during the multiplier phase pauses the multiplication and emits nothing.
- R6: `busy` is high while product bits 0 to `2W-2` are on the output. It is low in the cycle that shows the last product bit.
- R7: Loading a multiplicand during the multiplier or drain phase of a running multiplication does not disturb that multiplication. The newly loaded value is used by the next one.
- R8: A multiplier stream may start in the cycle where `busy` is low and the last product bit of the previous multiplication is on the output. Back-to-back multiplications therefore need no idle cycle.
- R9: A `mul_en` during the drain phase is ignored and sets `err`. So is a `mul_en` while idle when fewer than `W` multiplicand bits have been loaded since the previous multiplication started. `err` stays set until reset.
- R10: When `ld_mcand` and `mul_en` are high together, the bit is a multiplier bit only. It does not count toward the next multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sdin | input | 1 | Serial operand bit |
| ld_mcand | input | 1 | Strobe: `sdin` is a multiplicand bit |
| mul_en | input | 1 | Strobe: `sdin` is a multiplier bit |
| prod_bit | output | 1 | Serial product bit, least significant first |
| prod_vld | output | 1 | `prod_bit` carries a product bit |
| busy | output | 1 | A multiplication is in its multiplier or drain phase |
| err | output | 1 | Sticky flag for a rejected multiplier bit |

## Verification
The hardest case to reach from the ports is the seam between two multiplications. Here the last high bit of one product drains while the next multiplicand finishes loading, and the next multiplier stream starts in the single cycle where `busy` is low. The bench reaches this seam on every step of an exhaustive sweep over all operand pairs at a 5-bit width. It drives each multiplicand load into the drain window of the previous product and starts each multiplier stream with no idle cycle. Separate sequences insert stall cycles, over-length loads, coincident strobes and rejected starts.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    // Phase of the multiplication sequencer
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_MUL   = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;

    // Per-cycle command from the sequencer to the accumulator
    typedef struct packed {
        logic start;   // first multiplier bit: latch the multiplicand, clear the accumulator
        logic step;    // consume one multiplier bit
        logic drain;   // shift one high product bit out
    } acc_ctl_t;

    // Width of a counter that must hold the values 0..n
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bsm_hold.sv
module bsm_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         din,
    input  logic         take,
    output logic [W-1:0] mc,
    output logic         full
);
    import bsm_pkg::*;

    localparam int CW = cnt_width(W);

    logic [W-1:0]  shreg_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else begin
            if (ld) begin
                shreg_q <= {din, shreg_q[W-1:1]};
            end
            if (take) begin
                cnt_q <= ld ? CW'(1) : '0;
            end else if (ld && (cnt_q != CW'(W))) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign mc   = shreg_q;
    assign full = (cnt_q == CW'(W));

endmodule

// File: rtl/bsm_seq.sv
module bsm_seq #(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mul_en,
    input  logic              mc_full,
    output bsm_pkg::acc_ctl_t ctl,
    output bsm_pkg::phase_e   phase,
    output logic              busy,
    output logic              err
);
    import bsm_pkg::*;

    localparam int CW = cnt_width(W - 1);

    phase_e        ph_q, ph_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          err_q, err_d;
    logic          at_last;

    assign at_last = (cnt_q == CW'(W - 1));

    always_comb begin
        ph_d      = ph_q;
        cnt_d     = cnt_q;
        err_d     = err_q;
        ctl       = '0;
        unique case (ph_q)
            PH_IDLE: begin
                if (mul_en) begin
                    if (mc_full) begin
                        ctl.start = 1'b1;
                        ctl.step  = 1'b1;
                        ph_d      = PH_MUL;
                        cnt_d     = CW'(1);
                    end else begin
                        err_d = 1'b1;
                    end
                end
            end
            PH_MUL: begin
                if (mul_en) begin
                    ctl.step = 1'b1;
                    if (at_last) begin
                        ph_d  = PH_DRAIN;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            PH_DRAIN: begin
                ctl.drain = 1'b1;
                if (mul_en) begin
                    err_d = 1'b1;
                end
                if (at_last) begin
                    ph_d  = PH_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                ph_d  = PH_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            err_q <= err_d;
        end
    end

    assign phase = ph_q;
    assign busy  = (ph_q != PH_IDLE);
    assign err   = err_q;

endmodule

// File: rtl/bsm_accum.sv
module bsm_accum #(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bsm_pkg::acc_ctl_t ctl,
    input  logic              mbit,
    input  logic [W-1:0]      mc_new,
    output logic              pbit,
    output logic              pvld
);
    logic [W-1:0] mc_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] mc_sel;
    logic [W-1:0] acc_base;
    logic [W-1:0] addend;
    logic [W:0]   sum;

    assign mc_sel   = ctl.start ? mc_new : mc_q;
    assign acc_base = ctl.start ? '0 : acc_q;

    // Partial product: the multiplicand gated by the current multiplier bit
    for (genvar i = 0; i < W; i++) begin : g_gate
        assign addend[i] = mc_sel[i] & mbit;
    end

    // Carry-out lands in sum[W] and is kept in the accumulator top
    assign sum = {1'b0, acc_base} + {1'b0, addend};

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_q  <= '0;
            acc_q <= '0;
            pbit  <= 1'b0;
            pvld  <= 1'b0;
        end else begin
            pvld <= 1'b0;
            if (ctl.start) begin
                mc_q <= mc_new;
            end
            if (ctl.step) begin
                pbit  <= sum[0];
                acc_q <= sum[W:1];
                pvld  <= 1'b1;
            end else if (ctl.drain) begin
                pbit  <= acc_q[0];
                acc_q <= {1'b0, acc_q[W-1:1]};
                pvld  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/serial_mult.sv
module serial_mult #(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic sdin,
    input  logic ld_mcand,
    input  logic mul_en,
    output logic prod_bit,
    output logic prod_vld,
    output logic busy,
    output logic err
);
    import bsm_pkg::*;

    acc_ctl_t     ctl;
    phase_e       phase;
    logic [W-1:0] mc_hold;
    logic         mc_full;
    logic         hold_ld;

    // A multiplier strobe claims the shared data bit
    assign hold_ld = ld_mcand & ~mul_en;

    bsm_hold #(.W(W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .ld   (hold_ld),
        .din  (sdin),
        .take (ctl.start),
        .mc   (mc_hold),
        .full (mc_full)
    );

    bsm_seq #(.W(W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .mul_en  (mul_en),
        .mc_full (mc_full),
        .ctl     (ctl),
        .phase   (phase),
        .busy    (busy),
        .err     (err)
    );

    bsm_accum #(.W(W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .mbit   (sdin),
        .mc_new (mc_hold),
        .pbit   (prod_bit),
        .pvld   (prod_vld)
    );

endmodule

// File: rtl/bsm_chk.sv
module bsm_chk #(
    parameter int W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            mul_en,
    input logic            prod_vld,
    input logic            busy,
    input logic            err,
    input bsm_pkg::phase_e phase,
    input logic            mc_full
);
    import bsm_pkg::*;

    // R9
    drain_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DRAIN && mul_en) |=> err);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R9
    early_start_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && mul_en && !mc_full) |=> (err && !busy && !prod_vld));

    // R4
    drain_emit_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DRAIN) |=> prod_vld);

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !mul_en) |=> !prod_vld);

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && mul_en && mc_full) |=> (busy && prod_vld));

endmodule

bind serial_mult bsm_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mul_en   (mul_en),
    .prod_vld (prod_vld),
    .busy     (busy),
    .err      (err),
    .phase    (phase),
    .mc_full  (mc_full)
);

// File: tb/tb_serial_mult.sv
`timescale 1ns/1ps
module tb_serial_mult;
    localparam int W = 5;
    localparam int PW = 2 * W;

    logic clk = 1'b0;
    logic rst, sdin, ld_mcand, mul_en;
    logic prod_bit, prod_vld, busy, err;

    always #2.5 clk = ~clk;

    serial_mult #(.W(W)) dut (
        .clk(clk), .rst(rst), .sdin(sdin), .ld_mcand(ld_mcand), .mul_en(mul_en),
        .prod_bit(prod_bit), .prod_vld(prod_vld), .busy(busy), .err(err)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [PW-1:0] exp_q[$];
    logic [PW-1:0] cur;
    int vcnt = 0;
    bit busy_bad = 1'b0;
    bit gap_bad = 1'b0;

    task automatic chk(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_prod();
        logic [PW-1:0] e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected product", longint'(cur), 0);
        end else begin
            e = exp_q.pop_front();
            chk(cur == e, "R4 product value", longint'(cur), longint'(e));
        end
        chk(!busy_bad, "R6 busy during product", longint'(busy_bad), 0);
        chk(!gap_bad, "R4 drain gap", longint'(gap_bad), 0);
        busy_bad = 1'b0;
        gap_bad  = 1'b0;
        vcnt     = 0;
    endtask

    // One clock: wait for the falling edge, then sample the outputs
    task automatic tick();
        @(negedge clk);
        if (prod_vld) begin
            cur[vcnt] = prod_bit;
            if (busy !== (vcnt != PW - 1)) busy_bad = 1'b1;
            vcnt++;
            if (vcnt == PW) finish_prod();
        end else if (vcnt >= W) begin
            gap_bad = 1'b1;
        end
    endtask

    task automatic idle_inputs();
        sdin = 1'b0; ld_mcand = 1'b0; mul_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle_inputs();
        tick(); tick();
        rst = 1'b0;
        vcnt = 0; busy_bad = 1'b0; gap_bad = 1'b0;
        exp_q.delete();
    endtask

    task automatic load_bits(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            ld_mcand = 1'b1; sdin = bits[i];
            tick();
        end
        idle_inputs();
    endtask

    task automatic mul_run(input logic [W-1:0] mr, input logic [PW-1:0] expv);
        exp_q.push_back(expv);
        for (int i = 0; i < W; i++) begin
            mul_en = 1'b1; sdin = mr[i];
            tick();
            if (i == 0) chk(prod_vld === 1'b1, "R3 first bit latency", longint'(prod_vld), 1);
        end
        idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R5 watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] a, b;
        do_reset();
        // R1 reset state and quiet idle
        chk(prod_vld == 0 && busy == 0 && err == 0, "R1 reset outputs",
            {prod_vld, busy, err}, 0);
        tick(); tick();
        chk(prod_vld == 0 && busy == 0 && err == 0, "R1 idle outputs",
            {prod_vld, busy, err}, 0);

        // R7 R8: exhaustive sweep, next multiplicand loaded during each drain,
        // next multiplier stream starting with no idle cycle
        load_bits(16'(0), W);
        for (int idx = 0; idx < (1 << PW); idx++) begin
            a = W'(idx >> W);
            b = W'(idx);
            mul_run(b, PW'(a) * PW'(b));
            load_bits(16'((idx + 1) >> W), W);
        end
        tick();
        chk(exp_q.size() == 0, "R5 all products emitted", exp_q.size(), 0);
        chk(err == 0, "R8 back-to-back accepted", err, 0);

        // R5: stall cycles inside the multiplier phase
        load_bits(16'd27, W);
        exp_q.push_back(PW'(27 * 22));
        for (int i = 0; i < W; i++) begin
            mul_en = 1'b1; sdin = W'(22) >> i;
            tick();
            if (i == 1 || i == 3) begin
                idle_inputs();
                tick();
                chk(prod_vld == 0, "R5 stall emits nothing", prod_vld, 0);
            end
        end
        idle_inputs();
        repeat (W + 1) tick();
        chk(exp_q.size() == 0, "R5 stalled product emitted", exp_q.size(), 0);

        // R2: over-length load keeps the last W bits (value 19 after two junk bits)
        load_bits({7'd0, W'(19), 2'b11}, W + 2);
        mul_run(W'(29), PW'(19 * 29));
        repeat (W + 1) tick();
        chk(exp_q.size() == 0, "R2 over-length load product", exp_q.size(), 0);

        // R10: coincident strobes count as multiplier bits only
        load_bits(16'd13, W);
        exp_q.push_back(PW'(13 * 31));
        for (int i = 0; i < W; i++) begin
            mul_en = 1'b1; ld_mcand = 1'b1; sdin = 1'b1;
            tick();
        end
        idle_inputs();
        repeat (W + 1) tick();
        chk(exp_q.size() == 0, "R10 product with coincident strobes", exp_q.size(), 0);
        load_bits(16'd5, W - 1);
        mul_en = 1'b1; sdin = 1'b1;
        tick();
        idle_inputs();
        chk(err == 1 && prod_vld == 0, "R10 loads not counted", {err, prod_vld}, 2);

        // R9: multiplier bit during drain rejected, product unharmed, err sticky
        do_reset();
        load_bits(16'd23, W);
        mul_run(W'(17), PW'(23 * 17));
        for (int i = 0; i < W; i++) begin
            mul_en = (i == 2); sdin = 1'b1;
            tick();
        end
        idle_inputs();
        chk(err == 1, "R9 drain reject sets err", err, 1);
        chk(exp_q.size() == 0, "R9 drain product intact", exp_q.size(), 0);
        tick(); tick();
        chk(err == 1 && busy == 0 && prod_vld == 0, "R9 err sticky, no restart",
            {err, busy, prod_vld}, 4);

        // R9: start with partial multiplicand rejected
        do_reset();
        chk(err == 0, "R1 reset clears err", err, 0);
        load_bits(16'd3, 2);
        mul_en = 1'b1; sdin = 1'b1;
        tick();
        idle_inputs();
        chk(err == 1 && busy == 0 && prod_vld == 0, "R9 partial load reject",
            {err, busy, prod_vld}, 4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule